// File: doc/BRIEF.md
# Scrambled SRAM Bus Interface

This block connects the byte-wide memory port of an 8-bit processor to an external SRAM. It hides the program and its data from anyone who probes the external bus. Every logical address above the on-chip vector region is mapped to a physical SRAM address by a keyed, invertible transform. Each byte is encrypted on its way out and decrypted on its way back in. Both transforms are driven by one 64-bit key input, and the data mask also depends on the byte's logical address.

The external bus never sits idle. It runs back-to-back two-clock slots. A slot with no CPU work becomes a dummy read to an address taken from a key-seeded LFSR. A dummy read has the same timing and strobes as a real read, and its returned byte is dropped. The lowest 48 logical addresses, which include the reset fetch at 0000h, are kept in an on-chip vector RAM. When the CPU uses that region, the external bus shows a dummy read. This keeps the mapping of well-known addresses off the pins.

Top module: `scram_bus_top`

## Requirements
- R1: While rst_ni is low, ext_re_o, ext_we_o, ext_addr_o, ext_wdata_o, cpu_ack_o and cpu_rdata_o are all zero, and the vector RAM is cleared.
- R2: After reset is released, slots start at the second rising edge and then at every second edge. Throughout every slot, exactly one of ext_re_o or ext_we_o is high, so the bus is never idle.
- R3: A slot with no external CPU access is a dummy read whose ext_addr_o comes from a 16-bit LFSR. The seed is the XOR of the four 16-bit slices of key_i, or 16'hACE1 if that XOR is zero. The first slot uses the seed. The state advances once per slot by shifting left and taking in bit0 = s[15]^s[13]^s[12]^s[10].
- R4: A dummy slot never raises cpu_ack_o, and cpu_rdata_o changes only in a cycle where cpu_ack_o is high.
- R5: If cpu_req_i is high at a slot's first edge, that request is served in that slot. cpu_ack_o is then high for exactly the slot's second clock, so a request waits at most one slot behind a slot already running.
- R6: Logical addresses of 48 and above reach ext_addr_o through a keyed bijection. Reads and writes of one logical address use the same physical address, and distinct logical addresses use distinct physical ones.
- R7: A write to an external address drives ext_we_o high and ext_re_o low for the slot, with ext_wdata_o encrypted under the key and the logical address. Reading the same logical address back returns the original byte on cpu_rdata_o.
- R8: Logical addresses below 48 are served from the on-chip vector RAM: a write followed by a read returns the written byte. During such a slot ext_we_o stays low and ext_re_o is high, as a dummy read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 64 | Scrambling key |
| cpu_req_i | input | 1 | CPU access request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 16 | Logical address |
| cpu_wdata_i | input | 8 | Write byte in clear |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 8 | Read byte in clear, valid with cpu_ack_o |
| ext_addr_o | output | 16 | Physical SRAM address |
| ext_re_o | output | 1 | SRAM read strobe |
| ext_we_o | output | 1 | SRAM write strobe |
| ext_wdata_o | output | 8 | Encrypted write byte |
| ext_rdata_i | input | 8 | Encrypted byte from SRAM |

## Verification
The assertions assume the following about the inputs:
- key_i holds steady from reset release onwards.
- The CPU keeps cpu_req_i and its companion inputs stable until it sees cpu_ack_o.
- In the acknowledge cycle the CPU drops or replaces its request before the next edge, so that a finished access is not served a second time.
- The SRAM returns the stored byte in the second clock of a read slot.

The stimulus meets these conditions as follows:
- It changes key_i only while reset is asserted.
- It drives every request from the falling edge and clears it at the falling edge where the acknowledge is first seen.
- Its SRAM model updates its read data on the falling edge after the address is launched.

// File: rtl/scram_pkg.sv
package scram_pkg;

  typedef enum logic [1:0] {
    SL_NONE,
    SL_DUMMY,
    SL_EXT,
    SL_VEC
  } slot_e;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC; 4'h1: y = 4'h5; 4'h2: y = 4'h6; 4'h3: y = 4'hB;
      4'h4: y = 4'h9; 4'h5: y = 4'h0; 4'h6: y = 4'hA; 4'h7: y = 4'hD;
      4'h8: y = 4'h3; 4'h9: y = 4'hE; 4'hA: y = 4'hF; 4'hB: y = 4'h8;
      4'hC: y = 4'h4; 4'hD: y = 4'h7; 4'hE: y = 4'h1; default: y = 4'h2;
    endcase
    return y;
  endfunction

  function automatic logic [3:0] sbox4_inv(input logic [3:0] y);
    logic [3:0] x;
    x = '0;
    for (int i = 0; i < 16; i++) begin
      if (sbox4(4'(i)) == y) x = 4'(i);
    end
    return x;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input logic [2:0] s);
    logic [15:0] t;
    t = {x, x} << s;
    return t[15:8];
  endfunction

  function automatic logic [7:0] rotr8(input logic [7:0] x, input logic [2:0] s);
    logic [15:0] t;
    t = {x, x} >> s;
    return t[7:0];
  endfunction

endpackage

// File: rtl/addr_scrambler.sv
module addr_scrambler
  import scram_pkg::*;
#(
  parameter int AW       = 16,
  parameter int KW       = 64,
  parameter int ROUNDS   = 3,
  parameter int PERM_MUL = 7
) (
  input  logic [KW-1:0] key_i,
  input  logic [AW-1:0] laddr_i,
  output logic [AW-1:0] paddr_o
);
  localparam int NIB    = AW / 4;
  localparam int KSLOTS = KW / AW;

  logic [AW-1:0] stage [ROUNDS+1];
  assign stage[0] = laddr_i;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    logic [AW-1:0] mixed, subst, perm;
    assign mixed = stage[r] ^ key_i[(r % KSLOTS)*AW +: AW];
    for (genvar n = 0; n < NIB; n++) begin : g_nib
      assign subst[n*4 +: 4] = sbox4(mixed[n*4 +: 4]);
    end
    // odd multiplier mod power of two: a bit permutation
    for (genvar b = 0; b < AW; b++) begin : g_perm
      assign perm[b] = subst[(b*PERM_MUL) % AW];
    end
    assign stage[r+1] = perm;
  end

  assign paddr_o = stage[ROUNDS] ^ key_i[(ROUNDS % KSLOTS)*AW +: AW];

endmodule

// File: rtl/data_cipher.sv
module data_cipher
  import scram_pkg::*;
#(
  parameter int AW      = 16,
  parameter int KW      = 64,
  parameter bit DECRYPT = 1'b0
) (
  input  logic [KW-1:0] key_i,
  input  logic [AW-1:0] laddr_i,
  input  logic [7:0]    din_i,
  output logic [7:0]    dout_o
);
  logic [7:0] pre_mask, post_mask;
  logic [2:0] rot;

  assign pre_mask  = key_i[KW-1 -: 8] ^ laddr_i[7:0];
  assign post_mask = key_i[KW-9 -: 8] ^ laddr_i[AW-1 -: 8];
  assign rot       = key_i[18:16] ^ laddr_i[2:0];

  if (!DECRYPT) begin : g_enc
    logic [7:0] a, b, c;
    assign a      = din_i ^ pre_mask;
    assign b      = {sbox4(a[7:4]), sbox4(a[3:0])};
    assign c      = rotl8(b, rot);
    assign dout_o = c + post_mask;
  end else begin : g_dec
    logic [7:0] a, b, c;
    assign c      = din_i - post_mask;
    assign b      = rotr8(c, rot);
    assign a      = {sbox4_inv(b[7:4]), sbox4_inv(b[3:0])};
    assign dout_o = a ^ pre_mask;
  end

endmodule

// File: rtl/dummy_lfsr.sv
module dummy_lfsr #(
  parameter int             W        = 16,
  parameter int             KW       = 64,
  parameter logic [W-1:0]   TAPS     = 16'hB400,
  parameter logic [W-1:0]   ALT_SEED = 16'hACE1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [KW-1:0] key_i,
  input  logic          step_i,
  output logic [W-1:0]  value_o,
  output logic          seeded_o
);
  localparam int SLICES = KW / W;

  logic [W-1:0] fold, seed, state_q, state_nx;
  logic         seeded_q;

  always_comb begin
    fold = '0;
    for (int i = 0; i < SLICES; i++) fold ^= key_i[i*W +: W];
  end

  assign seed     = (fold == '0) ? ALT_SEED : fold;
  assign state_nx = {state_q[W-2:0], ^(state_q & TAPS)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      seeded_q <= 1'b0;
    end else if (!seeded_q) begin
      state_q  <= seed;
      seeded_q <= 1'b1;
    end else if (step_i) begin
      state_q  <= state_nx;
    end
  end

  assign value_o  = state_q;
  assign seeded_o = seeded_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seeded_q |-> (state_q != '0)); // R3

endmodule

// File: rtl/vector_ram.sv
module vector_ram #(
  parameter int DEPTH = 48,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && (int'(addr_i) < DEPTH)) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = (int'(addr_i) < DEPTH) ? mem_q[addr_i] : '0;

endmodule

// File: rtl/scram_bus_top.sv
module scram_bus_top
  import scram_pkg::*;
#(
  parameter int AW        = 16,
  parameter int KW        = 64,
  parameter int VEC_DEPTH = 48,
  parameter int ROUNDS    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [KW-1:0] key_i,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [7:0]    cpu_wdata_i,
  output logic          cpu_ack_o,
  output logic [7:0]    cpu_rdata_o,
  output logic [AW-1:0] ext_addr_o,
  output logic          ext_re_o,
  output logic          ext_we_o,
  output logic [7:0]    ext_wdata_o,
  input  logic [7:0]    ext_rdata_i
);
  localparam int VIW = $clog2(VEC_DEPTH);

  slot_e         slot_q;
  logic          phase_q;
  logic [AW-1:0] lat_addr_q;
  logic          lat_we_q;
  logic [7:0]    lat_wdata_q;
  logic [AW-1:0] ext_addr_q;
  logic          ext_re_q, ext_we_q;
  logic [7:0]    ext_wdata_q;
  logic          ack_q;
  logic [7:0]    rdata_q;

  logic          seeded, launch, capture, is_vec;
  logic [AW-1:0] lfsr_val, paddr;
  logic [7:0]    enc_out, dec_in, dec_out, vram_rdata;
  logic          vram_we;

  assign launch  = phase_q && seeded;
  assign capture = !phase_q && (slot_q != SL_NONE);
  assign is_vec  = cpu_addr_i < AW'(VEC_DEPTH);

  dummy_lfsr #(.W(AW), .KW(KW)) u_lfsr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_i    (key_i),
    .step_i   (launch),
    .value_o  (lfsr_val),
    .seeded_o (seeded)
  );

  addr_scrambler #(.AW(AW), .KW(KW), .ROUNDS(ROUNDS)) u_ascr (
    .key_i   (key_i),
    .laddr_i (cpu_addr_i),
    .paddr_o (paddr)
  );

  data_cipher #(.AW(AW), .KW(KW), .DECRYPT(1'b0)) u_enc (
    .key_i   (key_i),
    .laddr_i (cpu_addr_i),
    .din_i   (cpu_wdata_i),
    .dout_o  (enc_out)
  );

  // decrypt path also sees outgoing write data, for the inverse check
  assign dec_in = ext_we_q ? ext_wdata_q : ext_rdata_i;

  data_cipher #(.AW(AW), .KW(KW), .DECRYPT(1'b1)) u_dec (
    .key_i   (key_i),
    .laddr_i (lat_addr_q),
    .din_i   (dec_in),
    .dout_o  (dec_out)
  );

  assign vram_we = capture && (slot_q == SL_VEC) && lat_we_q;

  vector_ram #(.DEPTH(VEC_DEPTH), .IW(VIW)) u_vram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vram_we),
    .addr_i  (lat_addr_q[VIW-1:0]),
    .wdata_i (lat_wdata_q),
    .rdata_o (vram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q      <= SL_NONE;
      phase_q     <= 1'b0;
      lat_addr_q  <= '0;
      lat_we_q    <= 1'b0;
      lat_wdata_q <= '0;
      ext_addr_q  <= '0;
      ext_re_q    <= 1'b0;
      ext_we_q    <= 1'b0;
      ext_wdata_q <= '0;
      ack_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      phase_q <= ~phase_q;
      ack_q   <= 1'b0;
      if (launch) begin
        lat_addr_q  <= cpu_addr_i;
        lat_we_q    <= cpu_we_i;
        lat_wdata_q <= cpu_wdata_i;
        if (cpu_req_i && !is_vec) begin
          slot_q      <= SL_EXT;
          ext_addr_q  <= paddr;
          ext_re_q    <= !cpu_we_i;
          ext_we_q    <= cpu_we_i;
          ext_wdata_q <= cpu_we_i ? enc_out : 8'h00;
        end else begin
          // idle or vector slot: outside it looks like a plain read
          slot_q      <= cpu_req_i ? SL_VEC : SL_DUMMY;
          ext_addr_q  <= lfsr_val;
          ext_re_q    <= 1'b1;
          ext_we_q    <= 1'b0;
          ext_wdata_q <= 8'h00;
        end
      end
      if (capture) begin
        unique case (slot_q)
          SL_EXT: begin
            ack_q <= 1'b1;
            if (!lat_we_q) rdata_q <= dec_out;
          end
          SL_VEC: begin
            ack_q <= 1'b1;
            if (!lat_we_q) rdata_q <= vram_rdata;
          end
          default: ;
        endcase
      end
    end
  end

  assign cpu_ack_o   = ack_q;
  assign cpu_rdata_o = rdata_q;
  assign ext_addr_o  = ext_addr_q;
  assign ext_re_o    = ext_re_q;
  assign ext_we_o    = ext_we_q;
  assign ext_wdata_o = ext_wdata_q;

  AST_BUS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != SL_NONE) |-> (ext_re_o ^ ext_we_o)); // R2

  AST_SLOT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (slot_q != SL_NONE) && !phase_q); // R2

  AST_DUMMY_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture && (slot_q == SL_DUMMY)) |=> !cpu_ack_o); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cpu_rdata_o) |-> cpu_ack_o); // R4

  AST_REQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch && cpu_req_i) |=> !cpu_ack_o ##1 cpu_ack_o); // R5

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o); // R5

  AST_EXT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SL_EXT) |-> (lat_addr_q >= AW'(VEC_DEPTH))); // R6

  AST_DATA_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot_q == SL_EXT) && ext_we_o) |-> (dec_out == lat_wdata_q)); // R7

  AST_VEC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SL_VEC) |-> (!ext_we_o && ext_re_o)); // R8

endmodule

// File: tb/sim_scram_bus_top.sv
module sim_scram_bus_top;
  localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;
  localparam int NOPS = 13;
  // {we, addr, wdata, expected read}
  localparam logic [32:0] OPS [NOPS] = '{
    {1'b1, 16'h1234, 8'hA5, 8'h00},
    {1'b1, 16'h1235, 8'h3C, 8'h00},
    {1'b1, 16'h8000, 8'hFF, 8'h00},
    {1'b1, 16'h0010, 8'h77, 8'h00},
    {1'b1, 16'h002F, 8'h5A, 8'h00},
    {1'b1, 16'h0030, 8'hC3, 8'h00},
    {1'b0, 16'h1234, 8'h00, 8'hA5},
    {1'b0, 16'h0010, 8'h00, 8'h77},
    {1'b0, 16'h1235, 8'h00, 8'h3C},
    {1'b0, 16'h002F, 8'h00, 8'h5A},
    {1'b0, 16'h0000, 8'h00, 8'h00},
    {1'b0, 16'h0030, 8'h00, 8'hC3},
    {1'b0, 16'h8000, 8'h00, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [63:0] key;
  logic        cpu_req, cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_ack;
  logic [7:0]  cpu_rdata;
  logic [15:0] ext_addr;
  logic        ext_re, ext_we;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata = 8'h00;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  sram    [int];
  logic [15:0] phys_of [int];

  always #2 clk = ~clk;

  scram_bus_top u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .key_i       (key),
    .cpu_req_i   (cpu_req),
    .cpu_we_i    (cpu_we),
    .cpu_addr_i  (cpu_addr),
    .cpu_wdata_i (cpu_wdata),
    .cpu_ack_o   (cpu_ack),
    .cpu_rdata_o (cpu_rdata),
    .ext_addr_o  (ext_addr),
    .ext_re_o    (ext_re),
    .ext_we_o    (ext_we),
    .ext_wdata_o (ext_wdata),
    .ext_rdata_i (ext_rdata)
  );

  always @(negedge clk) begin
    if (ext_we) sram[int'(ext_addr)] = ext_wdata;
    ext_rdata <= sram.exists(int'(ext_addr)) ? sram[int'(ext_addr)] : 8'h00;
  end

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [15:0] lfsr_seed(input logic [63:0] k);
    logic [15:0] f;
    f = k[15:0] ^ k[31:16] ^ k[47:32] ^ k[63:48];
    return (f == 16'h0) ? 16'hACE1 : f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic do_op(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                       output logic [7:0] rd, output logic [15:0] pa,
                       output logic swe, output logic sre);
    int n;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_ack && n < 8);
    chk("R5 ack seen", 32'(cpu_ack), 32'd1);
    chk("R5 latency", 32'(n <= 3), 32'd1);
    rd = cpu_rdata; pa = ext_addr; swe = ext_we; sre = ext_re;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] exp_a;
    logic [7:0]  rd;
    logic [15:0] pa;
    logic        swe, sre;
    logic [15:0] ext_log [4];

    rst_ni = 1'b0; key = 64'h0; cpu_req = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ext_re", 32'(ext_re), 32'd0);
    chk("R1 ext_we", 32'(ext_we), 32'd0);
    chk("R1 ext_addr", 32'(ext_addr), 32'd0);
    chk("R1 ext_wdata", 32'(ext_wdata), 32'd0);
    chk("R1 ack", 32'(cpu_ack), 32'd0);
    chk("R1 rdata", 32'(cpu_rdata), 32'd0);

    // zero key fold -> fallback seed
    rst_ni = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3 zero-fold seed", 32'(ext_addr), 32'h0000ACE1);

    rst_ni = 1'b0; key = KEY;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    exp_a = lfsr_seed(KEY);
    for (int i = 0; i < 8; i++) begin
      chk("R3 dummy addr", 32'(ext_addr), 32'(exp_a));
      chk("R2 re first clk", 32'(ext_re), 32'd1);
      chk("R2 we first clk", 32'(ext_we), 32'd0);
      @(negedge clk);
      chk("R2 re second clk", 32'(ext_re), 32'd1);
      chk("R4 no ack on dummy", 32'(cpu_ack), 32'd0);
      chk("R4 rdata held", 32'(cpu_rdata), 32'd0);
      @(negedge clk);
      exp_a = lfsr_step(exp_a);
    end

    for (int i = 0; i < NOPS; i++) begin
      logic        we;
      logic [15:0] a;
      logic [7:0]  wd, ex;
      {we, a, wd, ex} = OPS[i];
      do_op(we, a, wd, rd, pa, swe, sre);
      if (a < 16'd48) begin
        chk("R8 no ext write", 32'(swe), 32'd0);
        chk("R8 dummy read shown", 32'(sre), 32'd1);
        if (!we) chk("R8 vector read", 32'(rd), 32'(ex));
      end else begin
        chk("R7 write strobe", 32'(swe), 32'(we));
        chk("R7 read strobe", 32'(sre), 32'(!we));
        if (we) phys_of[int'(a)] = pa;
        else begin
          chk("R6 same phys", 32'(pa), 32'(phys_of[int'(a)]));
          chk("R7 round trip", 32'(rd), 32'(ex));
        end
      end
    end

    ext_log[0] = phys_of[32'h1234]; ext_log[1] = phys_of[32'h1235];
    ext_log[2] = phys_of[32'h8000]; ext_log[3] = phys_of[32'h0030];
    for (int i = 0; i < 4; i++) begin
      for (int j = i + 1; j < 4; j++) begin
        chk("R6 distinct phys", 32'(ext_log[i] != ext_log[j]), 32'd1);
      end
    end

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R4 idle no ack", 32'(cpu_ack), 32'd0);
      chk("R4 idle rdata", 32'(cpu_rdata), 32'h000000FF);
      chk("R2 idle bus busy", 32'(ext_re ^ ext_we), 32'd1);
    end

    finish_run();
  end

endmodule